// File: doc/BRIEF.md
# Bit-serial HDLC frame transmitter with underrun handling

The block serialises bytes from a one-entry holding register onto a single data line, one line bit per clock. It frames them with 0x7E flags, inserts a 0 after any five consecutive 1s of payload, and appends a 16-bit frame check sequence. Between frames it idles on back-to-back flags. When the host fails to refill the holding register before the current byte has left the shifter, the frame is ended by itself. Depending on a control input, it closes with the check sequence and a flag, or it sends an abort pattern.

A sticky underrun status bit records that the frame was closed this way. Its rising edge produces a one-cycle interrupt request when interrupts are enabled. Software can clear the bit with a command, but only while transmission is enabled. Software can also have it cleared automatically each time a new frame begins. When transmission is disabled, the current data or flag character runs to its end. A check sequence cut short by a disable has its remaining slots filled with flag bits. After that the line marks at 1.

Top module: `sdlc_urun_tx`

## Requirements
- R1: After reset `txd_o` is 1, `urun_o` and `irq_o` are 0 and `buf_full_o` is 0.
- R2: While `tx_en_i` is 0 from reset, the line stays at 1. Once enabled, the line opens with flags (0x7E, sent LSB first), and it keeps sending flags whenever no frame is in progress.
- R3: A write (`wr_valid_i`) is taken only while `buf_full_o` is 0. A write while full is ignored. `buf_full_o` falls when the byte moves into the shifter, and bytes are sent LSB first.
- R4: After five consecutive 1s of data or check-sequence bits, a 0 is inserted. Flags and the abort pattern are never stuffed.
- R5: The check sequence is CRC-16 with the reflected polynomial 0x8408 (x^16+x^12+x^5+1), preset to all ones. It is sent complemented, LSB first, directly after the data. A receiver running the same CRC over data plus check sequence ends with 0xF0B8.
- R6: If the holding register is empty when a data byte ends and `abort_sel_i` is 0, the check sequence and then a closing flag follow. `urun_o` is set at the edge where the check sequence is loaded, before the closing flag is sent.
- R7: Under the same condition with `abort_sel_i` at 1, eight 1s are sent instead, followed by flags, and `urun_o` is set. No valid frame is delivered.
- R8: `irq_o` is high for exactly the first cycle in which `urun_o` reads 1 after reading 0, and only if `irq_en_i` is 1. It is never high at any other time.
- R9: A `urun_clr_i` pulse makes `urun_o` read 0 one cycle later, but only when `tx_en_i` is 1. When `tx_en_i` is 0 the pulse leaves `urun_o` unchanged.
- R10: With `auto_clr_i` at 1, `urun_o` is cleared at the edge where the first data byte of a frame is loaded. With `auto_clr_i` at 0, that load leaves `urun_o` unchanged.
- R11: If `tx_en_i` falls while a data byte or a flag is being shifted, that character is completed, and then the line marks at 1.
- R12: If `tx_en_i` falls while the check sequence is being shifted, each remaining slot of the 16 carries the flag bit with the same index modulo 8. After that the line marks at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one line bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable |
| abort_sel_i | input | 1 | Underrun action: 0 close with CRC, 1 abort |
| auto_clr_i | input | 1 | Clear underrun status at each frame start |
| irq_en_i | input | 1 | Interrupt enable for the status rise |
| urun_clr_i | input | 1 | Clear command for the underrun status |
| wr_valid_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Byte to transmit |
| buf_full_o | output | 1 | Holding register occupied |
| txd_o | output | 1 | Serial line output |
| urun_o | output | 1 | Sticky underrun / end-of-message status |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The status clear by command reads 0 one cycle after the command edge. The automatic clear lands in the same cycle in which `buf_full_o` first reads 0. The interrupt is due in the cycle in which `urun_o` first reads 1. The bench samples every output on the falling clock edge and drives inputs just after the rising edge, so each check looks at the exact cycle the requirement names. The line carries one register of latency, so frame contents, flag counts, aborts and idle marking are judged by a bit-level decoder running on the same falling edge. It removes stuffed zeros and recomputes the CRC, which makes those results independent of the latency. The truncated-CRC and mid-character disable cases are then judged by what the decoder saw, and by the absence of any 0 on the line in a window after the stop.

// File: rtl/sdlc_urun_pkg.sv
package sdlc_urun_pkg;
  localparam int unsigned CHAR_W = 8;
  localparam logic [CHAR_W-1:0] FLAG_PAT  = 8'h7E;
  localparam logic [CHAR_W-1:0] ABORT_PAT = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLAG,
    ST_DATA,
    ST_CRC,
    ST_ABORT
  } tx_state_e;
endpackage

// File: rtl/sdlc_fcs_gen.sv
module sdlc_fcs_gen #(
  parameter int unsigned   CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h8408
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic upd_i,
  input  logic bit_i,
  input  logic shift_i,
  output logic fcs_bit_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       crc_q <= '1;
    else if (init_i)   crc_q <= '1;
    else if (upd_i)    crc_q <= (crc_q >> 1) ^ ((crc_q[0] ^ bit_i) ? POLY : '0);
    else if (shift_i)  crc_q <= {1'b1, crc_q[CRC_W-1:1]};
  end

  // complemented, LSB first on the line
  assign fcs_bit_o = ~crc_q[0];
endmodule

// File: rtl/sdlc_zero_ins.sv
module sdlc_zero_ins #(
  parameter int unsigned RUN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic stuffable_i,
  output logic stuff_o
);
  localparam int unsigned CW = $clog2(RUN + 1);
  logic [CW-1:0] ones_q;

  assign stuff_o = (ones_q == CW'(RUN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ones_q <= '0;
    else if (stuff_o)              ones_q <= '0;
    else if (stuffable_i && bit_i) ones_q <= ones_q + 1'b1;
    else                           ones_q <= '0;
  end

  p_run_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= CW'(RUN));
endmodule

// File: rtl/sdlc_urun_status.sv
module sdlc_urun_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_cmd_i,
  input  logic tx_en_i,
  input  logic auto_i,
  input  logic irq_en_i,
  output logic urun_o,
  output logic irq_o
);
  logic urun_q, urun_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      urun_q <= 1'b0;
      urun_d <= 1'b0;
    end else begin
      urun_d <= urun_q;
      if (set_i)                              urun_q <= 1'b1;
      else if ((clr_cmd_i && tx_en_i) || auto_i) urun_q <= 1'b0;
    end
  end

  assign urun_o = urun_q;
  assign irq_o  = urun_q & ~urun_d & irq_en_i;

  p_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> urun_q);
  p_clr_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (urun_q && clr_cmd_i && !tx_en_i && !auto_i) |=> urun_q);
  p_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_cmd_i && tx_en_i && !set_i) |=> !urun_q);
  p_irq_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: rtl/sdlc_urun_tx.sv
module sdlc_urun_tx
  import sdlc_urun_pkg::*;
#(
  parameter int unsigned      CRC_W     = 16,
  parameter logic [CRC_W-1:0] CRC_POLY  = 16'h8408,
  parameter int unsigned      STUFF_RUN = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              abort_sel_i,
  input  logic              auto_clr_i,
  input  logic              irq_en_i,
  input  logic              urun_clr_i,
  input  logic              wr_valid_i,
  input  logic [CHAR_W-1:0] wr_data_i,
  output logic              buf_full_o,
  output logic              txd_o,
  output logic              urun_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(CRC_W);
  localparam int unsigned IDX_W = $clog2(CHAR_W);

  tx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  bit_cnt_q, bit_cnt_d;
  logic [CHAR_W-1:0] shreg_q, shreg_d;
  logic              cut_q, cut_d, cut_eff;
  logic [CHAR_W-1:0] buf_q;
  logic              buf_full_q;
  logic              txd_q;

  logic line_bit, cur_bit, stuffable, is_last, stuff_req, fcs_bit;
  logic load_buf, crc_init, crc_upd, crc_shift, urun_set, frame_start;

  sdlc_fcs_gen #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_fcs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .init_i   (crc_init),
    .upd_i    (crc_upd),
    .bit_i    (line_bit),
    .shift_i  (crc_shift),
    .fcs_bit_o(fcs_bit)
  );

  sdlc_zero_ins #(.RUN(STUFF_RUN)) u_zins (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_i      (line_bit),
    .stuffable_i(stuffable),
    .stuff_o    (stuff_req)
  );

  sdlc_urun_status u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (urun_set),
    .clr_cmd_i(urun_clr_i),
    .tx_en_i  (tx_en_i),
    .auto_i   (frame_start & auto_clr_i),
    .irq_en_i (irq_en_i),
    .urun_o   (urun_o),
    .irq_o    (irq_o)
  );

  always_comb begin
    state_d     = state_q;
    bit_cnt_d   = bit_cnt_q;
    shreg_d     = shreg_q;
    cut_d       = cut_q;
    line_bit    = 1'b1;
    stuffable   = 1'b0;
    load_buf    = 1'b0;
    crc_init    = 1'b0;
    crc_upd     = 1'b0;
    crc_shift   = 1'b0;
    urun_set    = 1'b0;
    frame_start = 1'b0;
    cut_eff     = cut_q | ~tx_en_i;
    is_last     = (state_q == ST_CRC) ? (bit_cnt_q == CNT_W'(CRC_W - 1))
                                      : (bit_cnt_q == CNT_W'(CHAR_W - 1));
    unique case (state_q)
      ST_FLAG, ST_DATA: cur_bit = shreg_q[0];
      ST_CRC:           cur_bit = cut_eff ? FLAG_PAT[bit_cnt_q[IDX_W-1:0]] : fcs_bit;
      default:          cur_bit = 1'b1;
    endcase

    if (stuff_req) begin
      line_bit = 1'b0;  // inserted zero; shifter stalls
    end else if (state_q == ST_IDLE) begin
      if (tx_en_i) begin
        state_d   = ST_FLAG;
        shreg_d   = FLAG_PAT;
        bit_cnt_d = '0;
      end
    end else begin
      line_bit  = cur_bit;
      stuffable = (state_q == ST_DATA) || ((state_q == ST_CRC) && !cut_eff);
      crc_upd   = (state_q == ST_DATA);
      crc_shift = (state_q == ST_CRC);
      if (state_q == ST_CRC) cut_d = cut_eff;
      if (!is_last) begin
        bit_cnt_d = bit_cnt_q + 1'b1;
        shreg_d   = shreg_q >> 1;
      end else begin
        bit_cnt_d = '0;
        cut_d     = 1'b0;
        shreg_d   = FLAG_PAT;
        unique case (state_q)
          ST_FLAG: begin
            if (!tx_en_i) state_d = ST_IDLE;
            else if (buf_full_q) begin
              state_d     = ST_DATA;
              shreg_d     = buf_q;
              load_buf    = 1'b1;
              crc_init    = 1'b1;
              frame_start = 1'b1;
            end else state_d = ST_FLAG;
          end
          ST_DATA: begin
            if (!tx_en_i) state_d = ST_IDLE;
            else if (buf_full_q) begin
              state_d  = ST_DATA;
              shreg_d  = buf_q;
              load_buf = 1'b1;
            end else begin
              urun_set = 1'b1;
              state_d  = abort_sel_i ? ST_ABORT : ST_CRC;
              shreg_d  = ABORT_PAT;
            end
          end
          ST_CRC:   state_d = cut_eff ? ST_IDLE : ST_FLAG;
          default:  state_d = tx_en_i ? ST_FLAG : ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      shreg_q    <= FLAG_PAT;
      cut_q      <= 1'b0;
      buf_q      <= '0;
      buf_full_q <= 1'b0;
      txd_q      <= 1'b1;
    end else begin
      state_q   <= state_d;
      bit_cnt_q <= bit_cnt_d;
      shreg_q   <= shreg_d;
      cut_q     <= cut_d;
      txd_q     <= line_bit;
      if (load_buf) buf_full_q <= 1'b0;
      else if (wr_valid_i && !buf_full_q) begin
        buf_q      <= wr_data_i;
        buf_full_q <= 1'b1;
      end
    end
  end

  assign buf_full_o = buf_full_q;
  assign txd_o      = txd_q;

  p_buf_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_full_q && wr_valid_i && !load_buf) |=> (buf_full_q && $stable(buf_q)));
  p_underrun_path_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urun_set |=> (state_q == ($past(abort_sel_i) ? ST_ABORT : ST_CRC)));
  p_idle_mark_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !stuff_req) |=> txd_o);
  p_cut_fill_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CRC && !tx_en_i && !stuff_req)
      |=> (txd_o == FLAG_PAT[$past(bit_cnt_q[IDX_W-1:0])]));
endmodule

// File: tb/sdlc_urun_tx_tb.sv
module sdlc_urun_tx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, abort_sel = 1'b0, auto_clr = 1'b0, irq_en = 1'b0;
  logic urun_clr = 1'b0, wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic buf_full, txd, urun, irq;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  sdlc_urun_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .abort_sel_i(abort_sel),
    .auto_clr_i(auto_clr), .irq_en_i(irq_en), .urun_clr_i(urun_clr),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .buf_full_o(buf_full),
    .txd_o(txd), .urun_o(urun), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- line decoder ----------------
  bit   rx_bits [0:2047];
  int   rx_cnt = 0, ones = 0, frames_rx = 0, aborts_rx = 0, flags_rx = 0;
  int   zero_cnt = 0, ab_nbits = 0, rx_len = 0, irq_cnt = 0, rise_frames = -1;
  bit   aborted = 1'b1, rx_ok = 1'b0, urun_prev = 1'b0;
  logic [7:0] rx_bytes [0:15];

  function automatic bit fcs_ok(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      logic fb = c[0] ^ rx_bits[i];
      c = c >> 1;
      if (fb) c = c ^ 16'h8408;
    end
    return (c == 16'hF0B8) && (n % 8 == 0) && (n >= 24);
  endfunction

  task automatic close_frame();
    int n = rx_cnt - 7;
    if (!aborted && n > 0) begin
      rx_ok  = fcs_ok(n);
      rx_len = (n >= 16) ? (n - 16) / 8 : 0;
      for (int b = 0; b < rx_len && b < 16; b++)
        for (int k = 0; k < 8; k++) rx_bytes[b][k] = rx_bits[b*8+k];
      frames_rx++;
    end
    rx_cnt = 0; aborted = 1'b0; ones = 0;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (txd) begin
      if (rx_cnt < 2048) rx_bits[rx_cnt] = 1'b1;
      if (rx_cnt < 2048) rx_cnt++;
      if (ones < 100) ones++;
      if (ones == 7) begin aborts_rx++; ab_nbits = rx_cnt - 7; aborted = 1'b1; end
    end else begin
      zero_cnt++;
      if (ones == 5) ones = 0;
      else if (ones == 6) begin flags_rx++; close_frame(); end
      else begin
        if (rx_cnt < 2048) rx_bits[rx_cnt] = 1'b0;
        if (rx_cnt < 2048) rx_cnt++;
        ones = 0;
      end
    end
    if (urun && !urun_prev) begin
      rise_frames = frames_rx;
      check(irq == irq_en, "R8", "irq on status rise", irq, irq_en);
    end else if (irq) begin
      check(1'b0, "R8", "irq without status rise", irq, 0);
    end
    if (irq) irq_cnt++;
    urun_prev = urun;
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(); @(posedge clk); #1; endtask
  task automatic idle(input int n); repeat (n) tick(); endtask

  task automatic put_byte(input logic [7:0] d);
    @(negedge clk);
    while (buf_full) @(negedge clk);
    tick(); wr_valid = 1'b1; wr_data = d;
    tick(); wr_valid = 1'b0;
  endtask

  task automatic pulse_clr();
    tick(); urun_clr = 1'b1;
    tick(); urun_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_frame(input int len, input bit abrt, input bit ien, input bit ff);
    logic [7:0] exp_b [0:15];
    int f0, a0, i0, bad;
    abort_sel = abrt; irq_en = ien;
    pulse_clr();
    f0 = frames_rx; a0 = aborts_rx; i0 = irq_cnt;
    for (int i = 0; i < len; i++) begin
      exp_b[i] = ff ? 8'hFF : 8'($urandom);
      put_byte(exp_b[i]);
    end
    if (!abrt) begin
      while (frames_rx == f0) @(negedge clk);
      bad = 0;
      for (int i = 0; i < len; i++) if (rx_bytes[i] !== exp_b[i]) bad++;
      check(rx_len == len, ff ? "R4" : "R3", "frame length", rx_len, len);
      check(bad == 0, ff ? "R4" : "R3", "byte mismatches", bad, 0);
      check(rx_ok, "R5", "fcs residue", rx_ok, 1);
      check(rise_frames == f0, "R6", "status set before closing flag", rise_frames, f0);
      check(urun == 1'b1, "R6", "status after crc close", urun, 1);
    end else begin
      while (aborts_rx == a0) @(negedge clk);
      idle(20);
      check(frames_rx == f0, "R7", "no frame after abort", frames_rx, f0);
      check(urun == 1'b1, "R7", "status after abort", urun, 1);
    end
    idle(12);
    check(irq_cnt - i0 == (ien ? 1 : 0), "R8", "irq pulses per underrun", irq_cnt - i0, ien ? 1 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int f0, fl0, a0, z0, wait_n;
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R1", "txd after reset", txd, 1);
    check(urun == 1'b0, "R1", "status after reset", urun, 0);
    check(irq == 1'b0, "R1", "irq after reset", irq, 0);
    check(buf_full == 1'b0, "R1", "buffer after reset", buf_full, 0);

    // disabled: buffered byte, second write ignored, line marks
    put_byte(8'h5A);
    tick(); wr_valid = 1'b1; wr_data = 8'hC3;
    tick(); wr_valid = 1'b0;
    z0 = zero_cnt;
    idle(50);
    check(zero_cnt == z0, "R2", "zeros while disabled", zero_cnt - z0, 0);
    check(buf_full == 1'b1, "R3", "buffer held while disabled", buf_full, 1);

    f0 = frames_rx; irq_en = 1'b1;
    tick(); tx_en = 1'b1;
    while (frames_rx == f0) @(negedge clk);
    check(rx_len == 1, "R3", "only first write sent (len)", rx_len, 1);
    check(rx_bytes[0] == 8'h5A, "R3", "only first write sent (byte)", rx_bytes[0], 8'h5A);
    check(rx_ok, "R5", "fcs of first frame", rx_ok, 1);
    check(buf_full == 1'b0, "R3", "buffer drained", buf_full, 0);

    fl0 = flags_rx; f0 = frames_rx;
    idle(48);
    check(flags_rx - fl0 >= 5, "R2", "idle flags", flags_rx - fl0, 5);
    check(frames_rx == f0, "R2", "no frames while idling", frames_rx, f0);

    run_frame(3, 1'b0, 1'b1, 1'b1);
    run_frame(2, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 12; i++)
      run_frame(1 + int'($urandom % 5), 1'($urandom), 1'($urandom), 1'b0);

    // R9: clear is gated by enable
    run_frame(1, 1'b1, 1'b0, 1'b0);
    tick(); tx_en = 1'b0;
    idle(30);
    pulse_clr();
    check(urun == 1'b1, "R9", "clear ignored while disabled", urun, 1);
    tick(); tx_en = 1'b1;
    pulse_clr();
    check(urun == 1'b0, "R9", "clear while enabled", urun, 0);

    // R10: automatic clear at frame start
    run_frame(1, 1'b1, 1'b0, 1'b0);
    auto_clr = 1'b1; a0 = aborts_rx;
    put_byte(8'h33);
    @(negedge clk);
    while (buf_full) @(negedge clk);
    check(urun == 1'b0, "R10", "auto clear on frame start", urun, 0);
    while (aborts_rx == a0) @(negedge clk);
    idle(12);
    auto_clr = 1'b0; a0 = aborts_rx;
    put_byte(8'h44);
    @(negedge clk);
    while (buf_full) @(negedge clk);
    check(urun == 1'b1, "R10", "no auto clear when off", urun, 1);
    while (aborts_rx == a0) @(negedge clk);
    idle(12);

    // R11: disable mid data byte
    abort_sel = 1'b0;
    pulse_clr();
    a0 = aborts_rx;
    put_byte(8'h24);
    @(negedge clk);
    while (buf_full) @(negedge clk);
    tick(); tx_en = 1'b0;
    while (aborts_rx == a0) @(negedge clk);
    check(ab_nbits == 8, "R11", "bits of stopped character", ab_nbits, 8);
    z0 = zero_cnt;
    idle(30);
    check(zero_cnt == z0, "R11", "line marks after stop", zero_cnt - z0, 0);
    check(urun == 1'b0, "R11", "no underrun on disable", urun, 0);

    // R12: disable mid check sequence
    tick(); tx_en = 1'b1;
    idle(20);
    f0 = frames_rx; a0 = aborts_rx;
    put_byte(8'($urandom));
    @(negedge clk);
    while (!urun) @(negedge clk);
    fl0 = flags_rx;
    idle(3); tx_en = 1'b0;
    wait_n = 0;
    while (flags_rx == fl0 && wait_n < 80) begin @(negedge clk); wait_n++; end
    idle(10);
    check(flags_rx >= fl0 + 1 && flags_rx <= fl0 + 2, "R12", "flag bits fill cut crc",
          flags_rx - fl0, 1);
    check(!(frames_rx > f0 && rx_ok), "R12", "cut frame not valid", rx_ok, 0);
    z0 = zero_cnt; fl0 = flags_rx;
    idle(40);
    check(zero_cnt == z0, "R12", "line marks after cut", zero_cnt - z0, 0);
    check(flags_rx == fl0, "R12", "no flags after cut", flags_rx - fl0, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule